// File: doc/BRIEF.md
# Event Counter Register Shell

This block wraps a 16-bit event counter in a small memory-mapped register set. An edge decoder outside the block turns input activity into single-cycle up and down pulses. This shell decides whether those pulses move the count, wraps the count at a programmable ceiling, and exposes the live count for software to read.

The block is programmed in a fixed order. Software first sets the enable bit. It then writes the ceiling and the compare value, which are only accepted while the block is enabled. It waits for the matching write-complete flags, acknowledges them through the clear register, and finally sets the start bit to begin continuous counting. Writing zero to the control register stops counting and returns the count to zero.

The configuration word selects how the external decoder should be set up: encoder mode, external-count mode and edge selection. It can only be changed while the block is disabled. Writes, reads and pulse inputs all use a single clock.

Top module: `evtcnt_regs`

## Requirements
- R1: After reset, control reads 0, configuration reads 0, ceiling reads 0xFFFF, compare reads 0, status reads 0 and the count reads 0.
- R2: The register offsets are: 0 control, 1 configuration, 2 ceiling, 3 compare, 4 status, 5 clear, 6 count. In the configuration word, bit 0 is encoder mode, bit 1 is external-count mode and bits 3:2 are the edge code (00 rising, 01 falling, 10 both). A configuration write made while the block is disabled reads back as written.
- R3: A configuration write made while the enable bit is set is ignored; the configuration reads back unchanged.
- R4: A ceiling or compare write made while the enable bit is clear is ignored; the register keeps its previous value.
- R5: An accepted compare write sets status bit 0 and an accepted ceiling write sets status bit 1. Each flag becomes visible exactly 2 clock edges after the edge that took the write, and not before.
- R6: Writing ones to clear-register bit 0 or bit 1 clears the matching status flag. Writing zeros leaves the flag set. A flag that is due to set wins over a clear in the same cycle.
- R7: Control bit 0 is enable and bit 1 is start. Counting runs once a control write has enable=1 and start=1, or has enable=1 while already running. Control readback gives enable in bit 0 and running in bit 1. Before counting runs, pulses leave the count unchanged.
- R8: While running, an up pulse increments the count. When the count is at or above the ceiling, an up pulse sets it to 0 instead.
- R9: While running, a down pulse decrements the count. When the count is 0, a down pulse loads the ceiling.
- R10: Up and down pulses in the same cycle leave the count unchanged.
- R11: A control write with enable=0 stops counting. The count then reads 0 from the following cycle on. Writes to the count offset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for bus, registers and counter |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| cnt_up | input | 1 | Up pulse from the edge decoder |
| cnt_dn | input | 1 | Down pulse from the edge decoder |

## Verification
The bench sweeps every small ceiling from 0 to 4 with a mix of up, down, tied and idle pulses, and compares the count after each pulse with an arithmetic model.
- A design that wraps one step late or early, or that handles a count above the ceiling wrongly, shows up as a count off by one at the wrap points.
- The write-complete flags are sampled on both sides of their 2-edge delay, so a flag that sets one cycle early or late is caught.
- Configuration writes while enabled and ceiling writes while disabled are followed by a readback, which catches a gate on the wrong condition.
- A clear that overrides a pending set is caught in the same way.
- Disabling in the middle of a count must zero the count and drop the running bit.

// File: rtl/evtcnt_pkg.sv
// Shared constants and types for the event counter register shell.
// Assumes a 3-bit register offset and a data word of at least 4 bits.
package evtcnt_pkg;

    localparam int ADDR_W    = 3;
    localparam int NUM_FLAGS = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CEIL  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CMP   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd6;

    // Index of each write-complete flag in the status and clear words
    localparam int FLG_CMP  = 0;
    localparam int FLG_CEIL = 1;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e pol;
        logic      ext_mode;
        logic      enc_mode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/evtcnt_wrsync.sv
// Write-complete flag: delays an accepted-write pulse by STAGES edges,
// then holds a sticky flag until software clears it.
// Assumes STAGES >= 1; a pending set beats a clear in the same cycle.
module evtcnt_wrsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage delay of the accepted write
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= set_i;
            end
        end else begin : g_multi
            // Shift the accepted write through the delay line
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], set_i};
            end
        end
    endgenerate

    // Sticky flag: set from the delay line, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_o <= 1'b0;
        else if (pipe_q[STAGES-1])   flag_o <= 1'b1;
        else if (clr_i)              flag_o <= 1'b0;
    end

endmodule

// File: rtl/evtcnt_core.sv
// Up/down event counter that wraps at a programmable ceiling.
// Assumes pulses are single-cycle and synchronous to clk; clear_i wins.
module evtcnt_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic         up_i,
    input  logic         dn_i,
    input  logic [W-1:0] ceil_i,
    output logic [W-1:0] cnt_o
);

    logic         step_up;
    logic         step_dn;
    logic [W-1:0] cnt_nxt;

    // Decode a single-direction step; ties cancel
    always_comb begin
        step_up = run_i && up_i && !dn_i;
        step_dn = run_i && dn_i && !up_i;
        cnt_nxt = cnt_o;
        if (step_up)      cnt_nxt = (cnt_o >= ceil_i) ? '0 : cnt_o + 1'b1;
        else if (step_dn) cnt_nxt = (cnt_o == '0) ? ceil_i : cnt_o - 1'b1;
    end

    // Count register with clear on disable
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_o <= '0;
        else if (clear_i) cnt_o <= '0;
        else              cnt_o <= cnt_nxt;
    end

endmodule

// File: rtl/evtcnt_regs.sv
// Register shell of the event counter: control, configuration, ceiling,
// compare, status, clear and count. Ceiling and compare are taken only
// while enabled; configuration only while disabled.
// Assumes a single clock and DATA_W >= CFG_W.
module evtcnt_regs
    import evtcnt_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_up,
    input  logic              cnt_dn
);

    localparam logic [DATA_W-1:0] CEIL_RST = '1;

    logic                 en_q;
    logic                 run_q;
    cfg_t                 cfg_q;
    logic [DATA_W-1:0]    ceil_q;
    logic [DATA_W-1:0]    cmp_q;
    logic [DATA_W-1:0]    cnt_w;
    logic [NUM_FLAGS-1:0] acc_set;
    logic [NUM_FLAGS-1:0] clr_req;
    logic [NUM_FLAGS-1:0] flags;
    logic                 wr_ctrl, wr_cfg, wr_ceil, wr_cmp, wr_clr;

    // Address decode of write strobes
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_cfg  = bus_wr && (bus_addr == OFS_CFG);
        wr_ceil = bus_wr && (bus_addr == OFS_CEIL);
        wr_cmp  = bus_wr && (bus_addr == OFS_CMP);
        wr_clr  = bus_wr && (bus_addr == OFS_CLR);
    end

    // Control: enable bit and running state started by the start bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            run_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q  <= bus_wdata[0];
            run_q <= bus_wdata[0] && (bus_wdata[1] || run_q);
        end
    end

    // Configuration: only changed while the block is disabled
    always_ff @(posedge clk) begin
        if (!rst_n)               cfg_q <= '0;
        else if (wr_cfg && !en_q) cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    // Ceiling and compare: only accepted while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ceil_q <= CEIL_RST;
            cmp_q  <= '0;
        end else begin
            if (wr_ceil && en_q) ceil_q <= bus_wdata;
            if (wr_cmp && en_q)  cmp_q  <= bus_wdata;
        end
    end

    // Per-flag set and clear requests
    always_comb begin
        acc_set           = '0;
        acc_set[FLG_CMP]  = wr_cmp && en_q;
        acc_set[FLG_CEIL] = wr_ceil && en_q;
        clr_req           = wr_clr ? bus_wdata[NUM_FLAGS-1:0] : '0;
    end

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            evtcnt_wrsync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (acc_set[i]),
                .clr_i  (clr_req[i]),
                .flag_o (flags[i])
            );
        end
    endgenerate

    evtcnt_core #(.W(DATA_W)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!en_q),
        .run_i   (run_q),
        .up_i    (cnt_up),
        .dn_i    (cnt_dn),
        .ceil_i  (ceil_q),
        .cnt_o   (cnt_w)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:  bus_rdata[1:0]          = {run_q, en_q};
            OFS_CFG:   bus_rdata[CFG_W-1:0]    = cfg_q;
            OFS_CEIL:  bus_rdata               = ceil_q;
            OFS_CMP:   bus_rdata               = cmp_q;
            OFS_STAT:  bus_rdata[NUM_FLAGS-1:0] = flags;
            OFS_COUNT: bus_rdata               = cnt_w;
            default:   bus_rdata               = '0;
        endcase
    end

endmodule

// File: rtl/evtcnt_chk.sv
// Checker for the event counter register shell, bound to evtcnt_regs.
// Assumes STAGES is well below the saturation value of its age counters.
module evtcnt_chk #(
    parameter int W      = 16,
    parameter int STAGES = 2,
    parameter int NF     = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_q,
    input logic          run_q,
    input logic [3:0]    cfg_bits,
    input logic [W-1:0]  ceil_q,
    input logic [W-1:0]  cnt,
    input logic          up,
    input logic          dn,
    input logic [NF-1:0] set_v,
    input logic [NF-1:0] flag_v
);

    localparam int AGE_W = $clog2(STAGES + 2) + 2;

    // Cycles since each flag's last accepted write, saturating
    logic [AGE_W-1:0] age_q [NF];
    generate
        for (genvar i = 0; i < NF; i++) begin : g_age
            always_ff @(posedge clk) begin
                if (!rst_n)                age_q[i] <= '1;
                else if (set_v[i])         age_q[i] <= '0;
                else if (age_q[i] != '1)   age_q[i] <= age_q[i] + 1'b1;
            end
            // R5
            okflag_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q[i] == AGE_W'(STAGES)) |-> flag_v[i]);
        end
    endgenerate

    // R11
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt == '0));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(cfg_bits));

    // R4
    ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(ceil_q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !run_q) |=> $stable(cnt));

    // R8
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && up && !dn && (cnt >= ceil_q)) |=> (cnt == '0));

    // R9
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && dn && !up && (cnt == '0)) |=> (cnt == $past(ceil_q)));

    // R10
    tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && up && dn) |=> $stable(cnt));

endmodule

bind evtcnt_regs evtcnt_chk #(
    .W      (DATA_W),
    .STAGES (SYNC_STAGES),
    .NF     (evtcnt_pkg::NUM_FLAGS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .run_q    (run_q),
    .cfg_bits (cfg_q),
    .ceil_q   (ceil_q),
    .cnt      (cnt_w),
    .up       (cnt_up),
    .dn       (cnt_dn),
    .set_v    (acc_set),
    .flag_v   (flags)
);

// File: tb/evtcnt_regs_tb.sv
`timescale 1ns/1ps
module evtcnt_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cnt_up = 1'b0;
    logic        cnt_dn = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_cnt;
    logic [15:0] exp_ceil;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    evtcnt_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_up    (cnt_up),
        .cnt_dn    (cnt_dn)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Kind: 0 up, 1 down, 2 both, 3 none; updates the model
    task automatic pulse(input int kind);
        cnt_up = (kind == 0) || (kind == 2);
        cnt_dn = (kind == 1) || (kind == 2);
        @(posedge clk);
        @(negedge clk);
        cnt_up = 1'b0; cnt_dn = 1'b0;
        if (kind == 0)      exp_cnt = (exp_cnt >= exp_ceil) ? 16'd0 : exp_cnt + 16'd1;
        else if (kind == 1) exp_cnt = (exp_cnt == 16'd0) ? exp_ceil : exp_cnt - 16'd1;
    endtask

    initial begin
        #(200000.0 * 5.0);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, rv); chk("R1 ctrl", rv, 16'h0000);
        rd(3'd1, rv); chk("R1 cfg", rv, 16'h0000);
        rd(3'd2, rv); chk("R1 ceiling", rv, 16'hFFFF);
        rd(3'd3, rv); chk("R1 compare", rv, 16'h0000);
        rd(3'd4, rv); chk("R1 status", rv, 16'h0000);
        rd(3'd6, rv); chk("R1 count", rv, 16'h0000);

        // R2 configuration fields while disabled, every code
        for (int v = 0; v < 16; v++) begin
            wr(3'd1, 16'(v));
            rd(3'd1, rv); chk("R2 cfg readback", rv, 16'(v));
        end
        wr(3'd1, 16'h0009);

        // R4 ceiling and compare ignored while disabled
        wr(3'd2, 16'h0005); rd(3'd2, rv); chk("R4 ceiling ignored", rv, 16'hFFFF);
        wr(3'd3, 16'h0007); rd(3'd3, rv); chk("R4 compare ignored", rv, 16'h0000);
        repeat (3) @(negedge clk);
        rd(3'd4, rv); chk("R4 no flag when disabled", rv, 16'h0000);

        // Enable without start
        wr(3'd0, 16'h0001);
        rd(3'd0, rv); chk("R7 enabled not running", rv, 16'h0001);

        // R3 configuration ignored while enabled
        wr(3'd1, 16'h0006); rd(3'd1, rv); chk("R3 cfg held", rv, 16'h0009);

        // R5 ceiling flag timing
        wr(3'd2, 16'h0005);
        rd(3'd4, rv); chk("R5 ceil flag after 0 edges", rv, 16'h0000);
        @(negedge clk); rd(3'd4, rv); chk("R5 ceil flag after 1 edge", rv, 16'h0000);
        @(negedge clk); rd(3'd4, rv); chk("R5 ceil flag after 2 edges", rv, 16'h0002);
        rd(3'd2, rv); chk("R4 ceiling taken when enabled", rv, 16'h0005);

        // R5 compare flag timing
        wr(3'd3, 16'h0003);
        @(negedge clk); rd(3'd4, rv); chk("R5 cmp flag after 1 edge", rv, 16'h0002);
        @(negedge clk); rd(3'd4, rv); chk("R5 cmp flag after 2 edges", rv, 16'h0003);
        rd(3'd3, rv); chk("R4 compare taken when enabled", rv, 16'h0003);

        // R6 clearing
        wr(3'd5, 16'h0000); rd(3'd4, rv); chk("R6 zero clear keeps flags", rv, 16'h0003);
        wr(3'd5, 16'h0001); rd(3'd4, rv); chk("R6 clear cmp only", rv, 16'h0002);
        wr(3'd5, 16'h0002); rd(3'd4, rv); chk("R6 clear ceiling", rv, 16'h0000);
        // R6 set wins over clear in the same cycle
        wr(3'd2, 16'h0005);
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 16'h0002; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk); bus_wr = 1'b0;
        rd(3'd4, rv); chk("R6 set beats clear", rv, 16'h0002);
        wr(3'd5, 16'h0003);
        rd(3'd4, rv); chk("R6 cleared after", rv, 16'h0000);

        // R7 pulses ignored before start
        exp_ceil = 16'h0005; exp_cnt = 16'h0000;
        pulse(0); pulse(1);
        rd(3'd6, rv); chk("R7 no count before start", rv, 16'h0000);
        wr(3'd0, 16'h0003);
        rd(3'd0, rv); chk("R7 running", rv, 16'h0003);
        wr(3'd0, 16'h0001);
        rd(3'd0, rv); chk("R7 enable write keeps running", rv, 16'h0003);

        // R8 up sweep across two wraps
        for (int k = 0; k < 13; k++) begin
            pulse(0);
            rd(3'd6, rv); chk("R8 up count", rv, 16'((k + 1) % 6));
        end
        // R9 down sweep across two wraps
        exp_cnt = 16'((13) % 6);
        for (int k = 0; k < 13; k++) begin
            pulse(1);
            rd(3'd6, rv); chk("R9 down count", rv, exp_cnt);
        end
        // R10 tie
        rd(3'd6, rv);
        pulse(2);
        rd(3'd6, rv); chk("R10 tie holds", rv, exp_cnt);
        // R11 count write has no effect
        wr(3'd6, 16'h0004);
        rd(3'd6, rv); chk("R11 count write ignored", rv, exp_cnt);

        // R11 disable clears count and running
        wr(3'd0, 16'h0000);
        rd(3'd0, rv); chk("R11 ctrl off", rv, 16'h0000);
        @(negedge clk);
        rd(3'd6, rv); chk("R11 count cleared", rv, 16'h0000);
        pulse(0);
        rd(3'd6, rv); chk("R11 no count when off", rv, 16'h0000);

        // Sweep of small ceilings with mixed pulse patterns
        for (int r = 0; r < 5; r++) begin
            wr(3'd0, 16'h0000);
            wr(3'd0, 16'h0001);
            wr(3'd2, 16'(r));
            wr(3'd0, 16'h0003);
            exp_ceil = 16'(r); exp_cnt = 16'd0;
            for (int k = 0; k < 3 * (r + 1) + 6; k++) begin
                int kind;
                kind = (k * 7 + r + k / 3) % 4;
                pulse(kind);
                rd(3'd6, rv);
                case (kind)
                    0: chk("R8 sweep up", rv, exp_cnt);
                    1: chk("R9 sweep down", rv, exp_cnt);
                    2: chk("R10 sweep tie", rv, exp_cnt);
                    default: chk("R7 sweep idle", rv, exp_cnt);
                endcase
            end
        end

        // R8 count above a lowered ceiling wraps to zero
        wr(3'd0, 16'h0000); wr(3'd0, 16'h0003);
        wr(3'd2, 16'h0006);
        exp_ceil = 16'h0006; exp_cnt = 16'd0;
        for (int k = 0; k < 5; k++) pulse(0);
        wr(3'd2, 16'h0002);
        exp_ceil = 16'h0002;
        pulse(0);
        rd(3'd6, rv); chk("R8 above ceiling wraps", rv, 16'h0000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule